// File: doc/BRIEF.md
# Serial Flash Whole-Array Erase Command Controller

This block is the slave-side command logic of a serial flash model for the command that erases the whole array. It listens on a four-wire serial port in clock mode 0. Data is sampled on the rising edge of the serial clock and driven on the falling edge. The port signals are oversampled by the system clock. Each command byte is shifted in most significant bit first. Three commands are recognised: arm-for-write, status read, and whole-array erase. The erase has two interchangeable codes.

A command is carried out only after chip select goes high again, and only if a full 8-bit code was received. An erase also needs the write-enable latch to be armed beforehand. It is refused if any bit of the per-sector lock vector is set, and a refused erase still disarms the latch. An accepted erase sends one system-clock pulse to the external array stub and starts a self-timed busy period, counted in system clock cycles. During that period only the status read is honoured.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Code 0x60 and code 0xC7 each start an erase when the latch is armed and no sector is locked. An accepted erase produces exactly one single-cycle pulse on `erase_pulse`.
- R2: An erase code received while the write-enable latch is clear has no effect: no pulse occurs and the status stays unchanged.
- R3: The erase starts only after chip select returns high. No pulse appears while chip select is still low, even after all 8 code bits have arrived.
- R4: If chip select returns high after fewer than 8 code bits, nothing happens: no pulse occurs and the latch keeps its state.
- R5: Bits clocked in after the 8-bit code are ignored, and the erase still executes.
- R6: If any bit of `sector_lock` is set when chip select returns high, the erase is refused and the write-enable latch is cleared.
- R7: After an accepted erase, busy stays set for ERASE_CYCLES system clock cycles and then clears by itself.
- R8: The write-enable latch is cleared in the same cycle that the erase starts, so a status read taken during the erase returns 0x01.
- R9: Code 0x05 returns the status byte, most significant bit first, starting with the first rising serial clock edge after the code. Bit 0 is busy, bit 1 is the write-enable latch, and all other bits are 0. While chip select stays low, the byte repeats, and each new byte is captured fresh from the live status.
- R10: While busy is set, the arm-for-write code and both erase codes are ignored. No second pulse occurs and the latch stays clear.
- R11: `spi_miso_oe` is high only while the part is selected and is shifting out a status reply. At all other times, including while an erase code is being received, the output is released.
- R12: Code 0x06 arms the write-enable latch when chip select returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high-impedance |
| sector_lock | input | NUM_SECTORS | One lock flag per sector; any set flag vetoes the erase |
| erase_pulse | output | 1 | One-cycle request to the array stub to erase everything |

## Verification
Two events can land in the same cycle: the erase timer expiring, which clears busy, and the status shifter loading a new byte during a continuous poll. The bench provokes this by arming the latch and starting an erase. It then holds chip select low and reads six status bytes back to back, so that the busy period ends in the middle of the read. Every byte must be either 0x01 or 0x00, because a byte is captured as a whole and never mixes old and new status. The sequence must never go back to busy, the first byte must show busy, and the last byte must show idle.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam logic [7:0] OP_WR_ARM  = 8'h06;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_WIPE_A  = 8'h60;
    localparam logic [7:0] OP_WIPE_B  = 8'hC7;

    localparam int OP_BITS   = 8;
    localparam int STAT_BUSY = 0;
    localparam int STAT_WEL  = 1;

    function automatic logic is_wipe(input logic [7:0] op);
        return (op == OP_WIPE_A) || (op == OP_WIPE_B);
    endfunction

    function automatic logic [7:0] pack_status(input logic busy, input logic wel);
        logic [7:0] s;
        s = '0;
        s[STAT_BUSY] = busy;
        s[STAT_WEL]  = wel;
        return s;
    endfunction

endpackage

// File: rtl/fec_spi_rx.sv
module fec_spi_rx
    import flash_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       selected,
    output logic       cs_rise,
    output logic       sck_fall,
    output logic       op_done,
    output logic [7:0] opcode
);

    localparam int CNT_W = $clog2(OP_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OP_BITS);

    typedef struct packed {
        logic [1:0]       cs_sync;
        logic             cs_prev;
        logic [1:0]       sck_sync;
        logic             sck_prev;
        logic [1:0]       mosi_sync;
        logic [7:0]       shreg;
        logic [CNT_W-1:0] bcnt;
    } rx_state_t;

    rx_state_t rx_d, rx_q;
    logic      sck_rise;

    always_comb begin
        rx_d           = rx_q;
        rx_d.cs_sync   = {rx_q.cs_sync[0], cs_n};
        rx_d.cs_prev   = rx_q.cs_sync[1];
        rx_d.sck_sync  = {rx_q.sck_sync[0], sck};
        rx_d.sck_prev  = rx_q.sck_sync[1];
        rx_d.mosi_sync = {rx_q.mosi_sync[0], mosi};

        sck_rise = rx_q.sck_sync[1] & ~rx_q.sck_prev;

        if (rx_q.cs_sync[1]) begin
            rx_d.bcnt = '0;
        end else if (sck_rise && (rx_q.bcnt != CNT_FULL)) begin
            rx_d.shreg = {rx_q.shreg[6:0], rx_q.mosi_sync[1]};
            rx_d.bcnt  = rx_q.bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q         <= '0;
            rx_q.cs_sync <= 2'b11;
            rx_q.cs_prev <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign selected = ~rx_q.cs_sync[1];
    assign cs_rise  = rx_q.cs_sync[1] & ~rx_q.cs_prev;
    assign sck_fall = ~rx_q.sck_sync[1] & rx_q.sck_prev;
    assign op_done  = (rx_q.bcnt == CNT_FULL);
    assign opcode   = rx_q.shreg;

    AST_OPCODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && op_done) |=> $stable(rx_q.shreg)); // R5

endmodule

// File: rtl/fec_cmd_core.sv
module fec_cmd_core
    import flash_erase_pkg::*;
#(
    parameter int NUM_SECTORS  = 8,
    parameter int ERASE_CYCLES = 400
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_rise,
    input  logic                   op_done,
    input  logic [7:0]             opcode,
    input  logic [NUM_SECTORS-1:0] sector_lock,
    output logic                   wel,
    output logic                   busy,
    output logic                   erase_pulse
);

    localparam int TMR_W = $clog2(ERASE_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(ERASE_CYCLES - 1);

    typedef struct packed {
        logic             wel;
        logic             busy;
        logic             pulse;
        logic [TMR_W-1:0] timer;
    } core_state_t;

    core_state_t cs_d, cs_q;

    always_comb begin
        cs_d       = cs_q;
        cs_d.pulse = 1'b0;

        if (cs_q.busy) begin
            if (cs_q.timer == '0) begin
                cs_d.busy = 1'b0;
            end else begin
                cs_d.timer = cs_q.timer - 1'b1;
            end
        end

        if (cs_rise && op_done && !cs_q.busy) begin
            if (opcode == OP_WR_ARM) begin
                cs_d.wel = 1'b1;
            end else if (is_wipe(opcode) && cs_q.wel) begin
                cs_d.wel = 1'b0;
                if (sector_lock == '0) begin
                    cs_d.pulse = 1'b1;
                    cs_d.busy  = 1'b1;
                    cs_d.timer = TMR_LOAD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign wel         = cs_q.wel;
    assign busy        = cs_q.busy;
    assign erase_pulse = cs_q.pulse;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.pulse |=> !cs_q.pulse); // R1
    AST_PULSE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.pulse |-> $past(cs_q.wel)); // R2
    AST_PULSE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.pulse |-> $past(cs_rise)); // R3
    AST_LOCK_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.pulse |-> ($past(sector_lock) == '0)); // R6
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_q.busy) |-> ($past(cs_q.timer) == '0)); // R7
    AST_WEL_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.busy |-> !cs_q.wel); // R8
    AST_BUSY_NO_REPULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_q.busy) && cs_q.busy) |-> !cs_q.pulse); // R10

endmodule

// File: rtl/fec_status_tx.sv
module fec_status_tx
    import flash_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       selected,
    input  logic       sck_fall,
    input  logic       op_done,
    input  logic [7:0] opcode,
    input  logic       wel,
    input  logic       busy,
    output logic       miso,
    output logic       miso_oe
);

    typedef struct packed {
        logic       active;
        logic       first;
        logic [2:0] cnt;
        logic [7:0] sr;
    } tx_state_t;

    tx_state_t tx_d, tx_q;
    logic [7:0] live_status;

    always_comb begin
        tx_d        = tx_q;
        live_status = pack_status(busy, wel);

        if (!selected) begin
            tx_d.active = 1'b0;
            tx_d.first  = 1'b0;
            tx_d.cnt    = '0;
        end else if (!tx_q.active) begin
            if (op_done && (opcode == OP_STAT_RD)) begin
                tx_d.active = 1'b1;
                tx_d.first  = 1'b1;
                tx_d.cnt    = '0;
                tx_d.sr     = live_status;
            end
        end else if (sck_fall) begin
            if (tx_q.first) begin
                tx_d.first = 1'b0;
            end else if (tx_q.cnt == 3'd7) begin
                tx_d.sr  = live_status;
                tx_d.cnt = '0;
            end else begin
                tx_d.sr  = {tx_q.sr[6:0], 1'b0};
                tx_d.cnt = tx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign miso    = tx_q.active & tx_q.sr[7];
    assign miso_oe = tx_q.active;

    AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |=> !tx_q.active); // R11

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int NUM_SECTORS  = 8,
    parameter int ERASE_CYCLES = 400
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_cs_n,
    input  logic                   spi_sck,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   spi_miso_oe,
    input  logic [NUM_SECTORS-1:0] sector_lock,
    output logic                   erase_pulse
);

    logic       selected;
    logic       cs_rise;
    logic       sck_fall;
    logic       op_done;
    logic [7:0] opcode;
    logic       wel;
    logic       busy;

    fec_spi_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (spi_cs_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .selected (selected),
        .cs_rise  (cs_rise),
        .sck_fall (sck_fall),
        .op_done  (op_done),
        .opcode   (opcode)
    );

    fec_cmd_core #(
        .NUM_SECTORS  (NUM_SECTORS),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_rise     (cs_rise),
        .op_done     (op_done),
        .opcode      (opcode),
        .sector_lock (sector_lock),
        .wel         (wel),
        .busy        (busy),
        .erase_pulse (erase_pulse)
    );

    fec_status_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .selected (selected),
        .sck_fall (sck_fall),
        .op_done  (op_done),
        .opcode   (opcode),
        .wel      (wel),
        .busy     (busy),
        .miso     (spi_miso),
        .miso_oe  (spi_miso_oe)
    );

    AST_OE_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> (op_done && (opcode == OP_STAT_RD))); // R11
    AST_FULL_CODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |-> $past(op_done)); // R4

endmodule

// File: tb/flash_erase_ctrl_test.sv
module flash_erase_ctrl_test;

    localparam int NUM_SECTORS  = 8;
    localparam int ERASE_CYCLES = 400;
    localparam int HALF         = 6;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   cs_n = 1'b1;
    logic                   sck = 1'b0;
    logic                   mosi = 1'b0;
    logic                   miso;
    logic                   miso_oe;
    logic [NUM_SECTORS-1:0] lock = '0;
    logic                   erase_pulse;

    always #10 clk = ~clk;

    flash_erase_ctrl #(
        .NUM_SECTORS  (NUM_SECTORS),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (cs_n),
        .spi_sck     (sck),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .sector_lock (lock),
        .erase_pulse (erase_pulse)
    );

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] val;
        logic [7:0] mask;
        string      tag;
    } exp_t;

    exp_t       expq[$];
    logic [7:0] got_byte;
    event       byte_ev;

    always @(posedge clk) if (rst_n && erase_pulse) pulses++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each received status byte with the queued expectation
    initial begin
        forever begin
            @(byte_ev);
            if (expq.size() == 0) begin
                chk(1'b0, "R9 unexpected status byte", got_byte, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(((got_byte ^ e.val) & e.mask) == 8'h00, e.tag, got_byte, e.val);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] v, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            mosi = v[7-i];
            wait_clk(HALF);
            rx = {rx[6:0], miso};
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_cmd(input logic [7:0] op, input int nbits);
        logic [7:0] rx;
        cs_low();
        spi_bits(op, nbits, rx);
        chk(miso_oe == 1'b0, "R11 output released during command", miso_oe, 0);
        cs_high();
    endtask

    task automatic status_read(input logic [7:0] exp_v, input string tag);
        logic [7:0] rx;
        expq.push_back('{val: exp_v, mask: 8'hFF, tag: tag});
        cs_low();
        spi_bits(8'h05, 8, rx);
        spi_bits(8'h00, 8, rx);
        got_byte = rx;
        ->byte_ev;
        chk(miso_oe == 1'b1, "R11 output driven during status reply", miso_oe, 1);
        cs_high();
        chk(miso_oe == 1'b0, "R11 output released after deselect", miso_oe, 0);
    endtask

    initial begin
        int base;
        logic [7:0] rx;
        bit seen_idle;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // reset state
        chk(miso_oe == 1'b0, "R11 reset output released", miso_oe, 0);
        chk(pulses == 0, "R1 reset no pulse", pulses, 0);
        status_read(8'h00, "R9 reset status");

        // erase without arming
        send_cmd(8'h60, 8);
        chk(pulses == 0, "R2 erase without latch", pulses, 0);
        status_read(8'h00, "R2 status unchanged");

        // arm
        send_cmd(8'h06, 8);
        status_read(8'h02, "R12 latch armed");

        // 0x60 deferred until release
        base = pulses;
        cs_low();
        spi_bits(8'h60, 8, rx);
        wait_clk(20);
        chk(pulses == base, "R3 no erase while selected", pulses, base);
        cs_high();
        chk(pulses == base + 1, "R1 R3 erase 0x60 on release", pulses, base + 1);
        status_read(8'h01, "R8 busy with latch clear");
        wait_clk(ERASE_CYCLES + 50);
        status_read(8'h00, "R7 busy cleared");

        // 0xC7, then commands during busy
        send_cmd(8'h06, 8);
        base = pulses;
        send_cmd(8'hC7, 8);
        chk(pulses == base + 1, "R1 erase 0xC7", pulses, base + 1);
        send_cmd(8'h06, 8);
        send_cmd(8'h60, 8);
        chk(pulses == base + 1, "R10 erase ignored while busy", pulses, base + 1);
        wait_clk(ERASE_CYCLES + 50);
        status_read(8'h00, "R10 arm ignored while busy");

        // incomplete codes
        send_cmd(8'h06, 8);
        base = pulses;
        send_cmd(8'h60, 7);
        send_cmd(8'hC7, 4);
        chk(pulses == base, "R4 short code no erase", pulses, base);
        status_read(8'h02, "R4 latch kept");

        // trailing bits ignored
        base = pulses;
        cs_low();
        spi_bits(8'h60, 8, rx);
        spi_bits(8'hFF, 8, rx);
        cs_high();
        chk(pulses == base + 1, "R5 trailing bits ignored", pulses, base + 1);
        wait_clk(ERASE_CYCLES + 50);

        // sector lock veto, two different sectors
        lock = 8'b0001_0000;
        send_cmd(8'h06, 8);
        base = pulses;
        send_cmd(8'h60, 8);
        chk(pulses == base, "R6 locked sector no erase", pulses, base);
        status_read(8'h00, "R6 latch cleared on veto");
        lock = 8'b1000_0000;
        send_cmd(8'h06, 8);
        send_cmd(8'hC7, 8);
        chk(pulses == base, "R6 top sector lock", pulses, base);
        status_read(8'h00, "R6 latch cleared second veto");
        lock = '0;

        // continuous poll across the end of the erase
        send_cmd(8'h06, 8);
        base = pulses;
        send_cmd(8'h60, 8);
        chk(pulses == base + 1, "R1 erase before poll", pulses, base + 1);
        expq.push_back('{val: 8'h01, mask: 8'hFF, tag: "R9 poll first busy"});
        for (int k = 0; k < 4; k++)
            expq.push_back('{val: 8'h00, mask: 8'hFE, tag: "R9 poll byte whole"});
        expq.push_back('{val: 8'h00, mask: 8'hFF, tag: "R7 poll last idle"});
        seen_idle = 0;
        cs_low();
        spi_bits(8'h05, 8, rx);
        for (int k = 0; k < 6; k++) begin
            spi_bits(8'h00, 8, rx);
            got_byte = rx;
            ->byte_ev;
            if (seen_idle)
                chk(rx[0] == 1'b0, "R7 busy never returns", rx[0], 0);
            if (rx[0] == 1'b0) seen_idle = 1;
        end
        cs_high();
        wait_clk(10);
        chk(expq.size() == 0, "R9 all poll bytes seen", expq.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule